// File: doc/BRIEF.md
# Display Window Update Sequencer

This block writes one rectangular region of a display controller that takes command-set style writes. A request gives a clip rectangle as `x1, y1, x2, y2`, where the two end coordinates are exclusive. The block then produces a byte stream for a downstream link transmitter. Each byte carries a flag that marks it as either a command or data. The stream first programs the column window, then the row window, and then opens a memory write. The pixel payload follows the memory write.

Pixels are pulled one at a time over a valid/ready input. Each pixel is either a 16-bit RGB565 word or a 24-bit RGB888 word. The RGB888 form is a 32-bit XRGB pixel with its pad byte already removed. RGB888 pixels are reduced to RGB565 as they pass through. Each 16-bit pixel is sent as two bytes, high byte first, unless the swap option is set.

A blank request ignores the given rectangle. It programs the full panel and streams zero pixels without pulling any input. A request is only taken while the display pipe is enabled and the block is idle.

Top module: `dcs_window_seq`

## Requirements
- R1: An update emits, in order: command byte 0x2A with four data bytes, command byte 0x2B with four data bytes, command byte 0x2C, and then the payload. Command bytes have `outDc`=0. Every parameter and payload byte has `outDc`=1.
- R2: The four data bytes after 0x2A are sent in this order: start column high byte, start column low byte, end column high byte, end column low byte. The start is `x1` and the end is the inclusive value `x2-1`. The bytes after 0x2B follow the same layout using `y1` and `y2-1`.
- R3: The payload is exactly `(x2-x1)*(y2-y1)*2` bytes. Exactly that many pixels are taken from the pixel input, and `busy` falls after the last payload byte is accepted. The caller must supply `x2>x1` and `y2>y1`.
- R4: With `srcIsXrgb`=0, each pixel is the 16-bit word `pixIn[15:0]`. Without swap, it is sent as `pixIn[15:8]` followed by `pixIn[7:0]`.
- R5: With `srcIsXrgb`=1, each pixel becomes `{pixIn[23:19], pixIn[15:10], pixIn[7:3]}` before it is sent.
- R6: With `swapBytes`=1, the low byte of each 16-bit pixel is sent before the high byte.
- R7: With `blankMode`=1, the windows are 0 to `PANEL_W-1` and 0 to `PANEL_H-1`, and `PANEL_W*PANEL_H*2` zero bytes follow. `pixReady` is never asserted during a blank update.
- R8: A `start` pulse while `pipeEnable` is 0 has no effect. `busy` stays 0 and no byte is produced.
- R9: A start is accepted only while idle, and `busy` is 1 from the next cycle. A `start` pulse while busy does not disturb the stream in progress.
- R10: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData` and `outDc` hold steady into the next cycle.
- R11: While idle, the block asserts neither `outValid` nor `pixReady`.
- R12: The mode flags and the rectangle are captured at the accepted start. Later changes on those inputs do not affect the update in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pipeEnable | input | 1 | Display pipe enabled; starts are ignored while low |
| start | input | 1 | Request pulse |
| blankMode | input | 1 | Fill the whole panel with zero pixels |
| srcIsXrgb | input | 1 | Source pixels are RGB888 and must be reduced |
| swapBytes | input | 1 | Send each pixel's low byte first |
| x1 | input | COORD_W | First column (inclusive) |
| y1 | input | COORD_W | First row (inclusive) |
| x2 | input | COORD_W | Column end (exclusive) |
| y2 | input | COORD_W | Row end (exclusive) |
| pixValid | input | 1 | Source pixel present |
| pixIn | input | 24 | Source pixel, RGB888 or RGB565 in the low 16 bits |
| pixReady | output | 1 | Pixel taken when high with `pixValid` |
| outValid | output | 1 | Output byte present |
| outData | output | 8 | Output byte |
| outDc | output | 1 | 0 for a command byte, 1 for a data byte |
| outReady | input | 1 | Downstream accepts the byte |
| busy | output | 1 | Update in progress |

## Verification
The hardest situation to reach is an interplay of three things in the same update: a stalled output byte, a pixel source that drops `pixValid`, and a second `start` arriving with a different rectangle. Only then can a mistake show up, such as capturing the wrong rectangle, pulling an extra pixel, or losing a stalled byte.

The stimulus sweeps every small rectangle near the origin, combined with all four format and swap combinations. Throughout each run, `outReady` and `pixValid` are throttled on coprime patterns. Some runs also inject a mid-update `start` that carries different coordinates and modes. Extra runs place coordinates across the 8-bit boundary so that the high parameter bytes are exercised.

// File: rtl/dcs_seq_pkg.sv
package dcs_seq_pkg;

  localparam logic [7:0] CMD_COL_WIN = 8'h2A;
  localparam logic [7:0] CMD_ROW_WIN = 8'h2B;
  localparam logic [7:0] CMD_MEM_WR  = 8'h2C;

  typedef enum logic [3:0] {
    ST_IDLE, ST_COL_CMD, ST_COL_PAR, ST_ROW_CMD, ST_ROW_PAR,
    ST_MEM_CMD, ST_FETCH, ST_PIX_A, ST_PIX_B
  } seqState_e;

  typedef enum logic [2:0] {
    BY_CMD_COL, BY_CMD_ROW, BY_CMD_MEM, BY_PAR_COL, BY_PAR_ROW, BY_PIX_A, BY_PIX_B
  } byteSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       latchWin;
    logic       latchPix;
    byteSel_e   sel;
    logic [1:0] parIdx;
  } seqStrobe_t;

endpackage

// File: rtl/dcs_seq_ctrl.sv
module dcs_seq_ctrl
  import dcs_seq_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PANEL_W = 320,
  parameter int PANEL_H = 240
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pipeEnable,
  input  logic               start,
  input  logic               blankMode,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  input  logic [COORD_W-1:0] x2,
  input  logic [COORD_W-1:0] y2,
  input  logic               pixValid,
  input  logic               outReady,
  output logic               pixReady,
  output logic               outValid,
  output logic               outDc,
  output logic               busy,
  output seqStrobe_t         strobe
);

  localparam int CNT_W = 2 * COORD_W;
  localparam logic [CNT_W-1:0] PANEL_PIX = CNT_W'(PANEL_W * PANEL_H);

  seqState_e        state;
  logic [1:0]       parCnt;
  logic [CNT_W-1:0] pixLeft;
  logic             blankR;
  logic             accept, take, fetchDone;
  logic [CNT_W-1:0] area;

  assign accept    = start && pipeEnable && (state == ST_IDLE);
  assign take      = outValid && outReady;
  assign fetchDone = (state == ST_FETCH) && (blankR || pixValid);
  assign area      = blankMode ? PANEL_PIX
                   : CNT_W'(x2 - x1) * CNT_W'(y2 - y1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      parCnt  <= '0;
      pixLeft <= '0;
      blankR  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_COL_CMD;
          pixLeft <= area;
          blankR  <= blankMode;
        end
        ST_COL_CMD: if (take) begin state <= ST_COL_PAR; parCnt <= '0; end
        ST_COL_PAR: if (take) begin
          parCnt <= parCnt + 2'd1;
          if (parCnt == 2'd3) state <= ST_ROW_CMD;
        end
        ST_ROW_CMD: if (take) begin state <= ST_ROW_PAR; parCnt <= '0; end
        ST_ROW_PAR: if (take) begin
          parCnt <= parCnt + 2'd1;
          if (parCnt == 2'd3) state <= ST_MEM_CMD;
        end
        ST_MEM_CMD: if (take) state <= (pixLeft == '0) ? ST_IDLE : ST_FETCH;
        ST_FETCH:   if (fetchDone) state <= ST_PIX_A;
        ST_PIX_A:   if (take) state <= ST_PIX_B;
        ST_PIX_B: if (take) begin
          pixLeft <= pixLeft - 1'b1;
          state   <= (pixLeft == CNT_W'(1)) ? ST_IDLE : ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    outValid = 1'b1;
    outDc    = 1'b1;
    strobe.sel = BY_PIX_A;
    unique case (state)
      ST_COL_CMD: begin outDc = 1'b0; strobe.sel = BY_CMD_COL; end
      ST_ROW_CMD: begin outDc = 1'b0; strobe.sel = BY_CMD_ROW; end
      ST_MEM_CMD: begin outDc = 1'b0; strobe.sel = BY_CMD_MEM; end
      ST_COL_PAR: strobe.sel = BY_PAR_COL;
      ST_ROW_PAR: strobe.sel = BY_PAR_ROW;
      ST_PIX_A:   strobe.sel = BY_PIX_A;
      ST_PIX_B:   strobe.sel = BY_PIX_B;
      default:    outValid = 1'b0;
    endcase
  end

  assign strobe.latchWin = accept;
  assign strobe.latchPix = fetchDone;
  assign strobe.parIdx   = parCnt;
  assign pixReady        = (state == ST_FETCH) && !blankR;
  assign busy            = (state != ST_IDLE);

endmodule

// File: rtl/dcs_seq_dp.sv
module dcs_seq_dp
  import dcs_seq_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PANEL_W = 320,
  parameter int PANEL_H = 240
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic               blankMode,
  input  logic               srcIsXrgb,
  input  logic               swapBytes,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  input  logic [COORD_W-1:0] x2,
  input  logic [COORD_W-1:0] y2,
  input  logic [23:0]        pixIn,
  output logic [7:0]         outData
);

  localparam logic [COORD_W-1:0] COL_LAST = COORD_W'(PANEL_W - 1);
  localparam logic [COORD_W-1:0] ROW_LAST = COORD_W'(PANEL_H - 1);

  logic [COORD_W-1:0] colStart, colEnd, rowStart, rowEnd;
  logic               xrgbR, swapR, blankR;
  logic [15:0]        pixWord, pixConv;
  logic [7:0]         pixFirst, pixSecond;

  // 8:8:8 to 5:6:5 by keeping the top bits of each channel
  assign pixConv = srcIsXrgbR(xrgbR) ? {pixIn[23:19], pixIn[15:10], pixIn[7:3]} : pixIn[15:0];

  function automatic logic srcIsXrgbR(input logic f);
    return f;
  endfunction

  function automatic logic [7:0] winByte(input logic [COORD_W-1:0] s,
                                         input logic [COORD_W-1:0] e,
                                         input logic [1:0] idx);
    logic [15:0] s16, e16;
    s16 = 16'(s);
    e16 = 16'(e);
    case (idx)
      2'd0:    return s16[15:8];
      2'd1:    return s16[7:0];
      2'd2:    return e16[15:8];
      default: return e16[7:0];
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colStart <= '0; colEnd <= '0; rowStart <= '0; rowEnd <= '0;
      xrgbR <= 1'b0; swapR <= 1'b0; blankR <= 1'b0;
      pixWord <= '0;
    end else begin
      if (strobe.latchWin) begin
        xrgbR  <= srcIsXrgb;
        swapR  <= swapBytes;
        blankR <= blankMode;
        if (blankMode) begin
          colStart <= '0; colEnd <= COL_LAST;
          rowStart <= '0; rowEnd <= ROW_LAST;
        end else begin
          colStart <= x1; colEnd <= x2 - 1'b1;
          rowStart <= y1; rowEnd <= y2 - 1'b1;
        end
      end
      if (strobe.latchPix) pixWord <= blankR ? 16'h0000 : pixConv;
    end
  end

  assign pixFirst  = swapR ? pixWord[7:0]  : pixWord[15:8];
  assign pixSecond = swapR ? pixWord[15:8] : pixWord[7:0];

  always_comb begin
    unique case (strobe.sel)
      BY_CMD_COL: outData = CMD_COL_WIN;
      BY_CMD_ROW: outData = CMD_ROW_WIN;
      BY_CMD_MEM: outData = CMD_MEM_WR;
      BY_PAR_COL: outData = winByte(colStart, colEnd, strobe.parIdx);
      BY_PAR_ROW: outData = winByte(rowStart, rowEnd, strobe.parIdx);
      BY_PIX_A:   outData = pixFirst;
      default:    outData = pixSecond;
    endcase
  end

endmodule

// File: rtl/dcs_window_seq.sv
module dcs_window_seq
  import dcs_seq_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PANEL_W = 320,
  parameter int PANEL_H = 240
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pipeEnable,
  input  logic               start,
  input  logic               blankMode,
  input  logic               srcIsXrgb,
  input  logic               swapBytes,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] y1,
  input  logic [COORD_W-1:0] x2,
  input  logic [COORD_W-1:0] y2,
  input  logic               pixValid,
  input  logic [23:0]        pixIn,
  output logic               pixReady,
  output logic               outValid,
  output logic [7:0]         outData,
  output logic               outDc,
  input  logic               outReady,
  output logic               busy
);

  seqStrobe_t strobe;

  dcs_seq_ctrl #(.COORD_W(COORD_W), .PANEL_W(PANEL_W), .PANEL_H(PANEL_H)) u_ctrl (
    .clk(clk), .rstN(rstN), .pipeEnable(pipeEnable), .start(start),
    .blankMode(blankMode), .x1(x1), .y1(y1), .x2(x2), .y2(y2),
    .pixValid(pixValid), .outReady(outReady), .pixReady(pixReady),
    .outValid(outValid), .outDc(outDc), .busy(busy), .strobe(strobe)
  );

  dcs_seq_dp #(.COORD_W(COORD_W), .PANEL_W(PANEL_W), .PANEL_H(PANEL_H)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .blankMode(blankMode),
    .srcIsXrgb(srcIsXrgb), .swapBytes(swapBytes),
    .x1(x1), .y1(y1), .x2(x2), .y2(y2), .pixIn(pixIn), .outData(outData)
  );

endmodule

// File: rtl/dcs_seq_chk.sv
module dcs_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pipeEnable,
  input logic       start,
  input logic       busy,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       outDc,
  input logic       pixReady
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!outValid && !pixReady)); // R11

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outDc))); // R10

  AST_CMD_CODES: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outDc) |-> (outData == 8'h2A || outData == 8'h2B || outData == 8'h2C)); // R1

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !pipeEnable) |=> !busy); // R8

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && pipeEnable) |=> busy); // R9

endmodule

bind dcs_window_seq dcs_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .pipeEnable(pipeEnable), .start(start), .busy(busy),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outDc(outDc),
  .pixReady(pixReady)
);

// File: tb/sim_dcs_window_seq.sv
`timescale 1ns/1ps
module sim_dcs_window_seq;

  localparam int PW = 8;
  localparam int PH = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pipeEnable = 1'b0, start = 1'b0, blankMode = 1'b0, srcIsXrgb = 1'b0, swapBytes = 1'b0;
  logic [15:0] x1 = '0, y1 = '0, x2 = '0, y2 = '0;
  logic pixValid = 1'b0, outReady = 1'b0;
  logic [23:0] pixIn = '0;
  logic pixReady, outValid, outDc, busy;
  logic [7:0] outData;

  int nChecks = 0, nFails = 0, cycles = 0;
  logic [7:0] expD [0:511];
  logic       expC [0:511];
  logic [7:0] gotD [0:511];
  logic       gotC [0:511];

  always #2.5 clk = ~clk;

  dcs_window_seq #(.COORD_W(16), .PANEL_W(PW), .PANEL_H(PH)) u0 (
    .clk(clk), .rstN(rstN), .pipeEnable(pipeEnable), .start(start),
    .blankMode(blankMode), .srcIsXrgb(srcIsXrgb), .swapBytes(swapBytes),
    .x1(x1), .y1(y1), .x2(x2), .y2(y2), .pixValid(pixValid), .pixIn(pixIn),
    .pixReady(pixReady), .outValid(outValid), .outData(outData), .outDc(outDc),
    .outReady(outReady), .busy(busy)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      nChecks++; nFails++;
      $display("FAIL R3 watchdog expired actual=%0d expected<150000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] genPix(input int k);
    return 24'(k * 24'h01F3B7 + 24'h5A3C91);
  endfunction

  task automatic runUpdate(input int ax1, input int ay1, input int ax2, input int ay2,
                           input bit blk, input bit xr, input bit sw, input bit dbl);
    int expN, gotN, pixIdx, cyc, area, sx, ex, sy, ey;
    bit done, prevStall, sawBlankReady;
    logic [7:0] prevD;
    logic prevC;
    string tag;
    sx = blk ? 0 : ax1; ex = blk ? PW-1 : ax2-1;
    sy = blk ? 0 : ay1; ey = blk ? PH-1 : ay2-1;
    area = blk ? PW*PH : (ax2-ax1)*(ay2-ay1);
    expN = 0;
    expD[expN] = 8'h2A; expC[expN] = 1'b0; expN++;
    expD[expN] = 8'(sx >> 8); expC[expN] = 1'b1; expN++;
    expD[expN] = 8'(sx);      expC[expN] = 1'b1; expN++;
    expD[expN] = 8'(ex >> 8); expC[expN] = 1'b1; expN++;
    expD[expN] = 8'(ex);      expC[expN] = 1'b1; expN++;
    expD[expN] = 8'h2B; expC[expN] = 1'b0; expN++;
    expD[expN] = 8'(sy >> 8); expC[expN] = 1'b1; expN++;
    expD[expN] = 8'(sy);      expC[expN] = 1'b1; expN++;
    expD[expN] = 8'(ey >> 8); expC[expN] = 1'b1; expN++;
    expD[expN] = 8'(ey);      expC[expN] = 1'b1; expN++;
    expD[expN] = 8'h2C; expC[expN] = 1'b0; expN++;
    for (int k = 0; k < area; k++) begin
      logic [23:0] p;
      logic [15:0] v;
      p = genPix(k);
      v = blk ? 16'h0 : (xr ? {p[23:19], p[15:10], p[7:3]} : p[15:0]);
      expD[expN] = sw ? v[7:0] : v[15:8]; expC[expN] = 1'b1; expN++;
      expD[expN] = sw ? v[15:8] : v[7:0]; expC[expN] = 1'b1; expN++;
    end

    gotN = 0; pixIdx = 0; cyc = 0; done = 0; prevStall = 0; sawBlankReady = 0;
    prevD = '0; prevC = 1'b0;
    @(negedge clk);
    x1 = 16'(ax1); y1 = 16'(ay1); x2 = 16'(ax2); y2 = 16'(ay2);
    blankMode = blk; srcIsXrgb = xr; swapBytes = sw; start = 1'b1;
    while (!done) begin
      @(negedge clk);
      start = 1'b0;
      if (cyc == 2) begin // R12: inputs change after capture
        x1 = 16'h0003; x2 = 16'h0004; blankMode = ~blk; srcIsXrgb = ~xr; swapBytes = ~sw;
      end
      if (dbl && cyc == 3) begin
        start = 1'b1; y1 = 16'h0001; y2 = 16'h0002;
      end
      outReady = (cyc % 3) != 1;
      pixValid = (cyc % 5) != 2;
      pixIn = genPix(pixIdx);
      #1;
      if (cyc == 0) chk("R9", int'(busy), 1, "busy after accepted start");
      if (prevStall) begin
        chk("R10", int'(outValid), 1, "valid held in stall");
        chk("R10", int'({outDc, outData}), int'({prevC, prevD}), "byte held in stall");
      end
      if (outValid && outReady && gotN < 512) begin
        gotD[gotN] = outData; gotC[gotN] = outDc; gotN++;
      end
      if (pixReady && pixValid) pixIdx++;
      if (pixReady && blk) sawBlankReady = 1;
      prevStall = outValid && !outReady; prevD = outData; prevC = outDc;
      if (!busy && cyc > 0) done = 1;
      cyc++;
      if (cyc > 20000) done = 1;
    end
    start = 1'b0;

    chk("R3", gotN, expN, "byte count");
    chk("R3", pixIdx, blk ? 0 : area, "pixels pulled");
    if (blk) chk("R7", int'(sawBlankReady), 0, "pixReady during blank");
    for (int i = 0; i < expN && i < gotN; i++) begin
      if (i == 0 || i == 5 || i == 10) tag = "R1";
      else if (i < 10) tag = blk ? "R7" : "R2";
      else if (blk) tag = "R7";
      else if (xr) tag = "R5";
      else if (sw) tag = "R6";
      else tag = "R4";
      if (dbl || i == 1) tag = (i < 11) ? tag : "R12";
      chk(tag, int'({gotC[i], gotD[i]}), int'({expC[i], expD[i]}), $sformatf("byte %0d {dc,data}", i));
    end
  endtask

  initial begin
    int idx;
    #12;
    chk("R11", int'(busy), 0, "busy in reset");
    chk("R11", int'(outValid), 0, "outValid in reset");
    chk("R11", int'(pixReady), 0, "pixReady in reset");
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R8: start ignored with pipe disabled
    x1 = 0; x2 = 2; y1 = 0; y2 = 2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 8; i++) begin
      #1;
      chk("R8", int'(busy), 0, "busy while pipe disabled");
      chk("R8", int'(outValid), 0, "output while pipe disabled");
      chk("R11", int'(pixReady), 0, "pixReady while idle");
      @(negedge clk);
    end
    pipeEnable = 1'b1;
    idx = 0;
    for (int ax1 = 0; ax1 < 3; ax1++)
      for (int w = 1; w <= 3; w++)
        for (int ay1 = 0; ay1 < 2; ay1++)
          for (int h = 1; h <= 2; h++) begin
            runUpdate(ax1, ay1, ax1 + w, ay1 + h, 1'b0, idx[0], idx[1], idx[2]);
            idx++;
          end
    // R2: coordinates spanning the byte boundary
    runUpdate(16'h00FF, 16'h0123, 16'h0101, 16'h0125, 1'b0, 1'b0, 1'b0, 1'b0);
    runUpdate(16'h0123, 16'h01FE, 16'h0126, 16'h0200, 1'b0, 1'b1, 1'b1, 1'b1);
    // R7: blank fill
    runUpdate(5, 5, 6, 6, 1'b1, 1'b0, 1'b0, 1'b0);
    runUpdate(1, 1, 3, 2, 1'b1, 1'b1, 1'b1, 1'b1);
    #1;
    chk("R11", int'(pixReady), 0, "pixReady idle at end");
    summary();
    $finish;
  end

endmodule